// File: doc/BRIEF.md
# Nibble-Mode Reverse Channel Receiver

This block takes bytes from a parallel-port peripheral over the reverse channel. The peripheral has no data path back to the host. It returns each byte as two 4-bit halves on four status lines. The receiver paces every half with a two-wire handshake:

- It asks for a nibble by pulling its host-busy line (`autofd_n_o`) low.
- The peripheral answers by driving its acknowledge line (`nack_n_i`) low.
- The receiver raises its line again and captures the four status bits.
- It then waits for the acknowledge line to return high before it asks for the next half.

The select-in and strobe outputs stay high for the whole transfer.

A transfer starts with a `start_i` pulse, and `len_i` gives the number of bytes. Each finished byte is offered on a valid/ready output together with the number of bytes still to come. The block holds the byte until the consumer takes it, and it asks for nothing more while it waits. When the transfer ends, `done_o` pulses for one cycle. In that cycle, `status_o` gives the result and `count_o` gives how many bytes the consumer accepted.

All waits are timed in pulses of `tick_i` and not in clock cycles. The first nibble of a byte may take up to `IDLE_TICKS`. Every later handshake step must happen within `RESP_TICKS`. The handshake inputs are assumed to be synchronised to `clk` before they reach the block.

The control state machine has seven states:

| State | Meaning |
|---|---|
| IDLE | Waiting for `start_i` |
| REQ_LO | First nibble requested |
| ACK_LO | Waiting for acknowledge release after the first nibble |
| REQ_HI | Second nibble requested |
| ACK_HI | Waiting for acknowledge release after the second nibble |
| OFFER | Byte presented on the output |
| FIN | Result reported |

The transitions are:

| From | Condition | To |
|---|---|---|
| IDLE | start with length 0 | FIN (OK) |
| IDLE | start with length above 0 | REQ_LO |
| REQ_LO | acknowledge low | ACK_LO |
| REQ_LO | idle limit reached | FIN (timeout) |
| ACK_LO | acknowledge high | REQ_HI |
| ACK_LO | response limit reached | FIN (timeout) |
| REQ_HI | acknowledge low | ACK_HI |
| REQ_HI | response limit reached | FIN (timeout) |
| ACK_HI | acknowledge high | OFFER |
| ACK_HI | response limit reached | FIN (I/O error) |
| OFFER | ready, and no bytes remain | FIN (OK) |
| OFFER | ready, and bytes remain | REQ_LO |
| FIN | always | IDLE |

Top module: `nibble_rev_rx`

## Requirements
- R1: After reset, `autofd_n_o` is 1, `valid_o` is 0 and `done_o` is 0.
- R2: The block requests a nibble by driving `autofd_n_o` to 0. While it does so, `selin_n_o` and `strobe_n_o` are 1.
- R3: Bit 0 of a nibble is nfault, bit 1 is select, bit 2 is perror and bit 3 is busy. The first nibble fills data bits 3:0 and the second fills bits 7:4.
- R4: A low on `nack_n_i` during a request raises `autofd_n_o` on the next clock edge. No new request is made until `nack_n_i` has returned high.
- R5: If no acknowledge arrives within `IDLE_TICKS` ticks of the first-nibble request, the transfer ends with status 1 (timeout). The count gives the bytes accepted before that point.
- R6: A timeout while waiting for the first-nibble release, or while waiting for the second nibble, ends the transfer with status 1.
- R7: If `nack_n_i` does not return high within `RESP_TICKS` ticks after the second nibble, the transfer ends with status 2 (I/O error). That byte is never presented.
- R8: While `valid_o` is 1 and `ready_i` is 0, `data_o` and `remain_o` hold steady and `autofd_n_o` stays 1.
- R9: `remain_o` gives the number of bytes still to come after the byte on `data_o`. It reads 0 on the last byte.
- R10: After the last byte is accepted, `done_o` pulses for one cycle with status 0 and `count_o` equal to `len_i`. A zero length finishes at once with count 0.
- R11: A `start_i` pulse during a transfer has no effect on that transfer.
- R12: The timeout counters advance only on cycles where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tick_i | input | 1 | Timebase pulse for the timeouts |
| start_i | input | 1 | Starts a transfer (ignored unless idle) |
| len_i | input | LEN_W | Number of bytes to receive |
| nack_n_i | input | 1 | Peripheral acknowledge, active low |
| nfault_n_i | input | 1 | Status line carrying nibble bit 0 |
| select_i | input | 1 | Status line carrying nibble bit 1 |
| perror_i | input | 1 | Status line carrying nibble bit 2 |
| busy_i | input | 1 | Status line carrying nibble bit 3 |
| autofd_n_o | output | 1 | Host busy / nibble request, low requests |
| selin_n_o | output | 1 | Select-in, held high |
| strobe_n_o | output | 1 | Strobe, held high |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | Byte available |
| ready_i | input | 1 | Consumer accepts the byte |
| remain_o | output | LEN_W | Bytes still to come after this one |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| status_o | output | 2 | 0 = OK, 1 = timeout, 2 = I/O error |
| count_o | output | LEN_W | Bytes accepted in the transfer |

## Verification
The paths that are hardest to reach are the three separate abort points inside one byte: a missing first-nibble release, a missing second nibble, and a second nibble whose acknowledge never lifts. Each one needs a peripheral that behaves correctly up to a chosen step and then stops. The bench peripheral model takes a mode argument that picks the step at which it goes silent. A scoreboard then confirms that the abandoned byte never reaches the output. Gating the tick shows that a stalled peripheral causes no timeout while time stands still. A consumer that withholds ready shows that the receiver stops asking for nibbles.

// File: rtl/nib_pkg.sv
package nib_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_LO,
        ST_ACK_LO,
        ST_REQ_HI,
        ST_ACK_HI,
        ST_OFFER,
        ST_FIN
    } nib_state_e;

    typedef enum logic [1:0] {
        XS_OK      = 2'd0,
        XS_TIMEOUT = 2'd1,
        XS_IOERR   = 2'd2
    } xfer_status_e;
endpackage

// File: rtl/nib_wait_timer.sv
module nib_wait_timer #(
    parameter int IDLE_TICKS = 2000,
    parameter int RESP_TICKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic tick_i,
    input  logic long_sel_i,
    output logic expired_o
);
    localparam int MAXT = (IDLE_TICKS > RESP_TICKS) ? IDLE_TICKS : RESP_TICKS;
    localparam int TW   = $clog2(MAXT + 1);
    localparam logic [TW-1:0] LONG_LAST  = TW'(IDLE_TICKS - 1);
    localparam logic [TW-1:0] SHORT_LAST = TW'(RESP_TICKS - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else if (tick_i)    cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = tick_i && (cnt_q == (long_sel_i ? LONG_LAST : SHORT_LAST));
endmodule

// File: rtl/nib_byte_asm.sv
module nib_byte_asm #(
    parameter int NIBBLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NIBBLES-1:0]   cap_i,
    input  logic [3:0]           nib_i,
    output logic [4*NIBBLES-1:0] byte_o
);
    for (genvar g = 0; g < NIBBLES; g++) begin : g_half
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        byte_o[g*4 +: 4] <= '0;
            else if (cap_i[g]) byte_o[g*4 +: 4] <= nib_i;
        end
    end
endmodule

// File: rtl/nib_xfer_cnt.sv
module nib_xfer_cnt #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             byte_done_i,
    input  logic             accept_i,
    output logic [LEN_W-1:0] remain_o,
    output logic [LEN_W-1:0] delivered_o,
    output logic             last_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_o    <= '0;
            delivered_o <= '0;
        end else begin
            if (load_i)           remain_o <= len_i;
            else if (byte_done_i) remain_o <= remain_o - 1'b1;
            if (load_i)           delivered_o <= '0;
            else if (accept_i)    delivered_o <= delivered_o + 1'b1;
        end
    end

    assign last_o = (remain_o == '0);
endmodule

// File: rtl/nibble_rev_rx.sv
module nibble_rev_rx
    import nib_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int IDLE_TICKS = 2000,
    parameter int RESP_TICKS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             nack_n_i,
    input  logic             nfault_n_i,
    input  logic             select_i,
    input  logic             perror_i,
    input  logic             busy_i,
    output logic             autofd_n_o,
    output logic             selin_n_o,
    output logic             strobe_n_o,
    output logic [7:0]       data_o,
    output logic             valid_o,
    input  logic             ready_i,
    output logic [LEN_W-1:0] remain_o,
    output logic             done_o,
    output logic [1:0]       status_o,
    output logic [LEN_W-1:0] count_o
);
    nib_state_e   state_q, state_d;
    xfer_status_e stat_q, stat_d;
    logic         expired, last;
    logic [1:0]   cap;
    logic [3:0]   nib;

    // state register and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stat_q  <= XS_OK;
        end else begin
            state_q <= state_d;
            stat_q  <= stat_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        stat_d  = stat_q;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                stat_d  = XS_OK;
                state_d = (len_i == '0) ? ST_FIN : ST_REQ_LO;
            end
            ST_REQ_LO: begin
                if (!nack_n_i)    state_d = ST_ACK_LO;
                else if (expired) begin state_d = ST_FIN; stat_d = XS_TIMEOUT; end
            end
            ST_ACK_LO: begin
                if (nack_n_i)     state_d = ST_REQ_HI;
                else if (expired) begin state_d = ST_FIN; stat_d = XS_TIMEOUT; end
            end
            ST_REQ_HI: begin
                if (!nack_n_i)    state_d = ST_ACK_HI;
                else if (expired) begin state_d = ST_FIN; stat_d = XS_TIMEOUT; end
            end
            ST_ACK_HI: begin
                if (nack_n_i)     state_d = ST_OFFER;
                else if (expired) begin state_d = ST_FIN; stat_d = XS_IOERR; end
            end
            ST_OFFER: if (ready_i) state_d = last ? ST_FIN : ST_REQ_LO;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        autofd_n_o = !((state_q == ST_REQ_LO) || (state_q == ST_REQ_HI));
        selin_n_o  = 1'b1;
        strobe_n_o = 1'b1;
        valid_o    = (state_q == ST_OFFER);
        done_o     = (state_q == ST_FIN);
        status_o   = stat_q;
    end

    assign nib    = {busy_i, perror_i, select_i, nfault_n_i};
    assign cap[0] = (state_q == ST_REQ_LO) && !nack_n_i;
    assign cap[1] = (state_q == ST_REQ_HI) && !nack_n_i;

    nib_wait_timer #(.IDLE_TICKS(IDLE_TICKS), .RESP_TICKS(RESP_TICKS)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (state_d != state_q),
        .tick_i     (tick_i),
        .long_sel_i (state_q == ST_REQ_LO),
        .expired_o  (expired)
    );

    nib_byte_asm #(.NIBBLES(2)) asm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .nib_i  (nib),
        .byte_o (data_o)
    );

    nib_xfer_cnt #(.LEN_W(LEN_W)) cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      ((state_q == ST_IDLE) && start_i),
        .len_i       (len_i),
        .byte_done_i ((state_q == ST_ACK_HI) && nack_n_i),
        .accept_i    (valid_o && ready_i),
        .remain_o    (remain_o),
        .delivered_o (count_o),
        .last_o      (last)
    );
endmodule

// File: rtl/nibble_rev_rx_chk.sv
module nibble_rev_rx_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nack_n_i,
    input logic             autofd_n_o,
    input logic [7:0]       data_o,
    input logic             valid_o,
    input logic             ready_i,
    input logic [LEN_W-1:0] remain_o,
    input logic             done_o,
    input logic [1:0]       status_o
);
    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(remain_o));

    assert_no_req_while_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> autofd_n_o);

    assert_release_follows_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(autofd_n_o) && !done_o |-> !$past(nack_n_i));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_status_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> status_o != 2'd3);

    assert_no_valid_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && valid_o));
endmodule

bind nibble_rev_rx nibble_rev_rx_chk #(.LEN_W(LEN_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .nack_n_i   (nack_n_i),
    .autofd_n_o (autofd_n_o),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .ready_i    (ready_i),
    .remain_o   (remain_o),
    .done_o     (done_o),
    .status_o   (status_o)
);

// File: tb/nibble_rev_rx_tb_top.sv
module nibble_rev_rx_tb_top;
    localparam int LW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ph = 1'b0, tick_en = 1'b1;
    logic start_i = 1'b0;
    logic [LW-1:0] len_i = '0;
    logic nack_n_i = 1'b1, nfault_n_i = 1'b0, select_i = 1'b0, perror_i = 1'b0, busy_i = 1'b0;
    logic ready_i = 1'b1;
    logic autofd_n_o, selin_n_o, strobe_n_o, valid_o, done_o;
    logic [7:0] data_o;
    logic [LW-1:0] remain_o, count_o;
    logic [1:0] status_o;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [15:0] expq[$];

    always #4 clk = ~clk;
    always @(posedge clk) tick_ph <= ~tick_ph;

    nibble_rev_rx #(.LEN_W(LW), .IDLE_TICKS(40), .RESP_TICKS(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_ph & tick_en), .start_i(start_i), .len_i(len_i),
        .nack_n_i(nack_n_i), .nfault_n_i(nfault_n_i), .select_i(select_i),
        .perror_i(perror_i), .busy_i(busy_i), .autofd_n_o(autofd_n_o),
        .selin_n_o(selin_n_o), .strobe_n_o(strobe_n_o), .data_o(data_o),
        .valid_o(valid_o), .ready_i(ready_i), .remain_o(remain_o),
        .done_o(done_o), .status_o(status_o), .count_o(count_o));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor: compare every accepted byte and its remaining count
    always @(negedge clk) begin
        if (rst_n && valid_o && ready_i) begin
            if (expq.size() == 0) begin
                chk(0, "R7 unexpected byte", int'(data_o), 0);
            end else begin
                logic [15:0] e;
                e = expq.pop_front();
                chk(data_o == e[7:0], "R3 byte", int'(data_o), int'(e[7:0]));
                chk(remain_o == e[15:8], "R9 remain", int'(remain_o), int'(e[15:8]));
            end
        end
    end

    task automatic wait_fd(input logic v);
        while (autofd_n_o !== v) @(negedge clk);
    endtask

    // peripheral model; mode 0 normal, 1 silent after first nibble, 2 hang final ack
    task automatic perif_byte(input logic [7:0] b, input int dly, input int mode);
        wait_fd(1'b0);
        chk(selin_n_o && strobe_n_o, "R2 lines", int'({selin_n_o, strobe_n_o}), 3);
        repeat (dly) @(negedge clk);
        {busy_i, perror_i, select_i, nfault_n_i} = b[3:0];
        nack_n_i = 1'b0;
        @(negedge clk);
        chk(autofd_n_o == 1'b1, "R4 release", int'(autofd_n_o), 1);
        repeat (2) begin
            @(negedge clk);
            chk(autofd_n_o == 1'b1, "R4 no early request", int'(autofd_n_o), 1);
        end
        nack_n_i = 1'b1;
        if (mode == 1) return;
        wait_fd(1'b0);
        {busy_i, perror_i, select_i, nfault_n_i} = b[7:4];
        nack_n_i = 1'b0;
        @(negedge clk);
        if (mode == 2) return;
        nack_n_i = 1'b1;
    endtask

    task automatic push(input logic [7:0] b, input int rem);
        expq.push_back({8'(rem), b});
    endtask

    task automatic begin_xfer(input int n);
        @(negedge clk);
        len_i = LW'(n);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input int st, input int cnt, input string req);
        int guard = 0;
        while (!done_o && guard < 2000) begin @(negedge clk); guard++; end
        chk(done_o == 1'b1, req, int'(done_o), 1);
        chk(status_o == 2'(st), req, int'(status_o), st);
        chk(count_o == LW'(cnt), req, int'(count_o), cnt);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(autofd_n_o == 1'b1 && valid_o == 1'b0 && done_o == 1'b0, "R1 reset",
            int'({autofd_n_o, valid_o, done_o}), 4);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R9 R10: three bytes, free-flowing consumer
        begin_xfer(3);
        push(8'hA5, 2); perif_byte(8'hA5, 3, 0);
        push(8'h3C, 1); perif_byte(8'h3C, 0, 0);
        push(8'hF0, 0); perif_byte(8'hF0, 5, 0);
        wait_done(0, 3, "R10 complete");

        // R8: consumer stalls
        ready_i = 1'b0;
        begin_xfer(2);
        push(8'h81, 1); perif_byte(8'h81, 1, 0);
        while (!valid_o) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(valid_o && autofd_n_o && data_o == 8'h81, "R8 stall",
                int'({valid_o, autofd_n_o, data_o}), int'({2'b11, 8'h81}));
        end
        ready_i = 1'b1;
        push(8'h7E, 0); perif_byte(8'h7E, 2, 0);
        wait_done(0, 2, "R8 finish");

        // R5: slow but legal first nibble, then silence
        begin_xfer(4);
        push(8'h5A, 3); perif_byte(8'h5A, 60, 0);
        wait_done(1, 1, "R5 idle timeout");

        // R6: second nibble never arrives
        begin_xfer(2);
        perif_byte(8'h99, 0, 1);
        wait_done(1, 0, "R6 response timeout");

        // R7: final acknowledge stuck low
        begin_xfer(2);
        push(8'h12, 1); perif_byte(8'h12, 0, 0);
        perif_byte(8'h34, 0, 2);
        wait_done(2, 1, "R7 io error");
        nack_n_i = 1'b1;
        chk(expq.size() == 0, "R7 queue", expq.size(), 0);

        // R10: zero length
        begin_xfer(0);
        chk(done_o == 1'b1 && count_o == '0 && status_o == 2'd0, "R10 zero length",
            int'({done_o, status_o}), 4);
        @(negedge clk);

        // R11: start during a transfer
        begin_xfer(2);
        @(negedge clk);
        len_i = LW'(9); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        push(8'hC3, 1); perif_byte(8'hC3, 0, 0);
        push(8'h0F, 0); perif_byte(8'h0F, 0, 0);
        wait_done(0, 2, "R11 start ignored");

        // R12: no ticks, no timeout
        tick_en = 1'b0;
        begin_xfer(1);
        repeat (300) @(negedge clk);
        chk(done_o == 1'b0 && autofd_n_o == 1'b0, "R12 frozen timer",
            int'({done_o, autofd_n_o}), 0);
        tick_en = 1'b1;
        push(8'h66, 0); perif_byte(8'h66, 0, 0);
        wait_done(0, 1, "R12 resume");

        finish_run();
    end
endmodule